// File: doc/BRIEF.md
# Sequential Shift-Add Unsigned Multiplier

This block forms the full-width product of two unsigned W-bit operands (W = 32 by default, so the result is 64 bits). It uses one W-bit adder and a single 2W-bit register. A start pulse latches the multiplicand into a holding register, loads the multiplier into the low half of the product register and clears the high half. After that, each clock cycle does one iteration. The register's least significant bit chooses between adding the multiplicand into the high half and leaving the high half as it is. The whole register, with the adder's carry-out above it, then moves one place to the right.

A multiplication takes exactly W iterations. The last iteration drops busy and raises done on the same clock edge. The finished product then stays on the output, and done stays high, until software or a sequencer issues the next start. A start that arrives while busy is high has no effect. The operand inputs are read only on the edge that accepts a start, so they may change freely while the multiplication runs.

Top module: `shift_add_mul`

## Requirements
- R1: When rst is sampled high on a rising clock edge (synchronous, active high), the next cycle shows busy = 0, done = 0 and product = 0.
- R2: A start sampled while busy is low is accepted. On the next cycle busy = 1, done = 0, and product equals the multiplier operand zero-extended to 2W bits, with the high half all zeros.
- R3: Exactly W clock edges after the edge that accepts start, busy falls and done rises on the same edge. At that point product equals multiplicand × multiplier as an unsigned 2W-bit value.
- R4: After k of the W iterations, product equals (multiplicand × (multiplier mod 2^k)) · 2^(W−k) + (multiplier >> k). In each iteration with bit 0 = 0, the register simply shifts right by one.
- R5: The operand inputs are captured only on the accepting edge. Changes to them while busy do not alter the result or the timing.
- R6: A start that arrives while busy is high is ignored. The result, the intermediate values and the completion edge stay as they would have been without it.
- R7: While done is high and no start arrives, done stays high and product holds its value.
- R8: The adder's carry-out enters the register's most significant bit on each shift, so all-ones operands give (2^W − 1)^2.
- R9: A zero operand on either side yields product 0. The small case 13 × 6 yields 78.
- R10: busy and done are never high at the same time.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; every register updates on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | One-cycle request to begin a multiplication; ignored while busy |
| multiplicand_i | input | W | Unsigned multiplicand, sampled when start is accepted |
| multiplier_i | input | W | Unsigned multiplier, sampled when start is accepted |
| busy | output | 1 | High while the W iterations are running |
| done | output | 1 | High from completion until the next accepted start |
| product | output | 2W | Product register; holds the final product while done is high |

## Verification
Since the product register is driven straight onto the output, an error in a single iteration shows up in product on the very next clock. This covers a wrong add decision, a dropped carry and a bad shift. The bench compares the register every cycle against the closed-form partial value of R4, so it catches such faults without waiting for completion. An error in the iteration counter appears as busy falling or done rising on the wrong edge, which the latency checks catch within one cycle of the expected edge. A multiplicand latch that accepts a new value mid-run shows up in the partial values on the next cycle whose multiplier bit is 1.

// File: rtl/mul_pkg.sv
package mul_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_DONE = 2'd2
  } mul_state_e;

endpackage

// File: rtl/mul_adder.sv
// Ripple-carry adder, W bits, carry-in tied low.
module mul_adder #(
  parameter int W = 32
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic [W-1:0] sum,
  output logic         cout
);

  logic [W:0] carry;

  assign carry[0] = 1'b0;

  generate
    for (genvar i = 0; i < W; i++) begin : g_bit
      assign sum[i]     = a[i] ^ b[i] ^ carry[i];
      assign carry[i+1] = (a[i] & b[i]) | (carry[i] & (a[i] ^ b[i]));
    end
  endgenerate

  assign cout = carry[W];

endmodule

// File: rtl/mul_ctrl.sv
// Sequencer: accepts start when not running, counts W iterations.
module mul_ctrl
  import mul_pkg::*;
#(
  parameter int W = 32
) (
  input  logic clk,
  input  logic rst,
  input  logic start,
  output logic load,
  output logic step,
  output logic busy,
  output logic done
);

  localparam int CW = (W > 1) ? $clog2(W) : 1;
  localparam logic [CW-1:0] LAST = CW'(W - 1);

  mul_state_e    state_q;
  logic [CW-1:0] iter_q;

  assign load = start && (state_q != ST_RUN);
  assign step = (state_q == ST_RUN);

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
      iter_q  <= '0;
      busy    <= 1'b0;
      done    <= 1'b0;
    end else if (load) begin
      state_q <= ST_RUN;
      iter_q  <= '0;
      busy    <= 1'b1;
      done    <= 1'b0;
    end else if (state_q == ST_RUN) begin
      if (iter_q == LAST) begin
        state_q <= ST_DONE;
        busy    <= 1'b0;
        done    <= 1'b1;
      end else begin
        iter_q <= iter_q + 1'b1;
      end
    end
  end

endmodule

// File: rtl/mul_datapath.sv
// Fixed multiplicand, combined product/multiplier register shifting right.
module mul_datapath #(
  parameter int W = 32
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           load,
  input  logic           step,
  input  logic [W-1:0]   mcand_in,
  input  logic [W-1:0]   mplier_in,
  output logic [2*W-1:0] prod
);

  localparam int PW = 2 * W;

  logic [W-1:0] mcand_q;
  logic [W-1:0] addend;
  logic [W-1:0] hi_sum;
  logic         hi_cout;

  assign addend = prod[0] ? mcand_q : '0;

  mul_adder #(.W(W)) u_add (
    .a    (prod[PW-1:W]),
    .b    (addend),
    .sum  (hi_sum),
    .cout (hi_cout)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      mcand_q <= '0;
      prod    <= '0;
    end else if (load) begin
      mcand_q <= mcand_in;
      prod    <= {{W{1'b0}}, mplier_in};
    end else if (step) begin
      prod    <= {hi_cout, hi_sum, prod[W-1:1]};
    end
  end

endmodule

// File: rtl/shift_add_mul.sv
module shift_add_mul #(
  parameter int W = 32
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           start,
  input  logic [W-1:0]   multiplicand_i,
  input  logic [W-1:0]   multiplier_i,
  output logic           busy,
  output logic           done,
  output logic [2*W-1:0] product
);

  logic load;
  logic step;

  mul_ctrl #(.W(W)) u_ctrl (
    .clk   (clk),
    .rst   (rst),
    .start (start),
    .load  (load),
    .step  (step),
    .busy  (busy),
    .done  (done)
  );

  mul_datapath #(.W(W)) u_dp (
    .clk       (clk),
    .rst       (rst),
    .load      (load),
    .step      (step),
    .mcand_in  (multiplicand_i),
    .mplier_in (multiplier_i),
    .prod      (product)
  );

endmodule

// File: rtl/shift_add_mul_checker.sv
module shift_add_mul_checker #(
  parameter int W = 32
) (
  input logic           clk,
  input logic           rst,
  input logic           start,
  input logic [W-1:0]   multiplicand_i,
  input logic [W-1:0]   multiplier_i,
  input logic           busy,
  input logic           done,
  input logic [2*W-1:0] product
);

  localparam int PW = 2 * W;

  logic [31:0]  run_cnt;
  logic [W-1:0] a_cap;
  logic [W-1:0] b_cap;
  logic [PW-1:0] full_prod;

  always_ff @(posedge clk) begin
    if (rst) begin
      run_cnt <= '0;
      a_cap   <= '0;
      b_cap   <= '0;
    end else if (start && !busy) begin
      run_cnt <= '0;
      a_cap   <= multiplicand_i;
      b_cap   <= multiplier_i;
    end else if (busy) begin
      run_cnt <= run_cnt + 1;
    end
  end

  assign full_prod = {{W{1'b0}}, a_cap} * {{W{1'b0}}, b_cap};

  assert_reset_R1: assert property (@(posedge clk)
    rst |=> (!busy && !done && product == '0));

  assert_load_R2: assert property (@(posedge clk) disable iff (rst)
    (start && !busy) |=> (busy && !done && product == {{W{1'b0}}, $past(multiplier_i)}));

  assert_latency_R3: assert property (@(posedge clk) disable iff (rst)
    $rose(done) |-> (run_cnt == 32'(W)));

  assert_result_R3: assert property (@(posedge clk) disable iff (rst)
    $rose(done) |-> (product == full_prod));

  assert_hold_step_R4: assert property (@(posedge clk) disable iff (rst)
    (busy && !product[0]) |=> (product == ($past(product) >> 1)));

  assert_add_step_R4: assert property (@(posedge clk) disable iff (rst)
    (busy && product[0]) |=> (product[W-2:0] == $past(product[W-1:1])));

  assert_stable_R7: assert property (@(posedge clk) disable iff (rst)
    (done && !start) |=> (done && $stable(product)));

  assert_exclusive_R10: assert property (@(posedge clk) disable iff (rst)
    !(busy && done));

endmodule

bind shift_add_mul shift_add_mul_checker #(.W(W)) u_chk (
  .clk            (clk),
  .rst            (rst),
  .start          (start),
  .multiplicand_i (multiplicand_i),
  .multiplier_i   (multiplier_i),
  .busy           (busy),
  .done           (done),
  .product        (product)
);

// File: tb/shift_add_mul_bench.sv
module shift_add_mul_bench;

  localparam int W  = 32;
  localparam int PW = 2 * W;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          start = 1'b0;
  logic [W-1:0]  a_in = '0;
  logic [W-1:0]  b_in = '0;
  logic          busy;
  logic          done;
  logic [PW-1:0] product;

  int n_checks = 0;
  int n_pass   = 0;
  int cyc      = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  shift_add_mul #(.W(W)) u_shift_add_mul (
    .clk            (clk),
    .rst            (rst),
    .start          (start),
    .multiplicand_i (a_in),
    .multiplier_i   (b_in),
    .busy           (busy),
    .done           (done),
    .product        (product)
  );

  // Closed-form register value after k iterations.
  function automatic logic [PW-1:0] partial(logic [W-1:0] x, logic [W-1:0] y, int k);
    logic [PW-1:0] mask;
    logic [PW-1:0] ylow;
    if (k == 0) mask = '0;
    else        mask = {PW{1'b1}} >> (PW - k);
    ylow = {{W{1'b0}}, y} & mask;
    return (({{W{1'b0}}, x} * ylow) << (W - k)) | ({{W{1'b0}}, y} >> k);
  endfunction

  // Reference model
  logic          m_busy = 1'b0;
  logic          m_done = 1'b0;
  logic [PW-1:0] m_prod = '0;
  logic [W-1:0]  m_a = '0;
  logic [W-1:0]  m_b = '0;
  int            m_k = 0;

  always @(posedge clk) begin
    if (rst) begin
      m_busy = 1'b0; m_done = 1'b0; m_prod = '0; m_k = 0;
    end else if (start && !m_busy) begin
      m_a = a_in; m_b = b_in; m_k = 0;
      m_busy = 1'b1; m_done = 1'b0;
      m_prod = partial(m_a, m_b, 0);
    end else if (m_busy) begin
      m_k = m_k + 1;
      m_prod = partial(m_a, m_b, m_k);
      if (m_k == W) begin
        m_busy = 1'b0; m_done = 1'b1;
      end
    end
  end

  task automatic check(bit ok, string tag, logic [PW-1:0] act, logic [PW-1:0] exp);
    n_checks++;
    if (ok) n_pass++;
    else $display("FAIL %s actual=%h expected=%h", tag, act, exp);
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("%0d/%0d checks passed", n_pass, n_checks);
      $finish;
    end
  endtask

  // Per-cycle comparison against the model (R4, R10)
  always @(negedge clk) begin
    if (!rst) begin
      check(product == m_prod, "R4 cycle product", product, m_prod);
      check(busy == m_busy && done == m_done, "R10 cycle busy/done",
            {62'd0, busy, done}, {62'd0, m_busy, m_done});
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      n_checks++;
      $display("FAIL watchdog actual=%0d expected<=150000", cyc);
      finish_run();
    end
  end

  // scramble: change operand inputs while running (R5)
  // extra_start: pulse start mid-run with other operands (R6)
  task automatic run(logic [W-1:0] x, logic [W-1:0] y, string tag,
                     bit scramble, bit extra_start);
    int n;
    logic [PW-1:0] exp;
    exp = {{W{1'b0}}, x} * {{W{1'b0}}, y};
    @(negedge clk);
    a_in = x; b_in = y; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check(busy && !done && product == {{W{1'b0}}, y}, {tag, " R2 load"},
          product, {{W{1'b0}}, y});
    n = 1;
    while (!done && n < 4 * W) begin
      if (scramble) begin a_in = $urandom; b_in = $urandom; end
      start = (extra_start && n == W / 2);
      @(negedge clk);
      n++;
    end
    start = 1'b0;
    check(n - 1 == W, {tag, " R3 latency"}, PW'(n - 1), PW'(W));
    check(done && !busy && product == exp, {tag, " R3 result"}, product, exp);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(!busy && !done && product == '0, "R1 reset state", product, '0);
    rst = 1'b0;
    @(negedge clk);
    check(!busy && !done && product == '0, "R1 after release", product, '0);

    run(32'd13, 32'd6, "R9 13x6", 1'b0, 1'b0);
    check(product == 64'd78, "R9 value 78", product, 64'd78);
    run(32'd0, 32'hDEAD_BEEF, "R9 zero mcand", 1'b0, 1'b0);
    check(product == '0, "R9 zero mcand", product, '0);
    run(32'h1234_5678, 32'd0, "R9 zero mplier", 1'b0, 1'b0);
    check(product == '0, "R9 zero mplier", product, '0);
    run(32'hFFFF_FFFF, 32'hFFFF_FFFF, "R8 all ones", 1'b0, 1'b0);
    check(product == 64'hFFFF_FFFE_0000_0001, "R8 carry kept", product,
          64'hFFFF_FFFE_0000_0001);
    run(32'h8000_0001, 32'hFFFF_FFFF, "R8 carry chain", 1'b0, 1'b0);

    // R7: result holds while idle
    begin
      logic [PW-1:0] held;
      held = product;
      repeat (6) @(negedge clk);
      check(done && product == held, "R7 hold", product, held);
    end

    run(32'hCAFE_F00D, 32'h0BAD_1DEA, "R5 scrambled inputs", 1'b1, 1'b0);
    run(32'h0000_FFFF, 32'hA5A5_A5A5, "R6 start while busy", 1'b0, 1'b1);
    run(32'h7, 32'h3, "R6 scrambled and start", 1'b1, 1'b1);

    for (int i = 0; i < 6; i++) begin
      run(32'($urandom), 32'($urandom), "R4 random", 1'b0, 1'b0);
    end

    // R1: reset mid-run
    @(negedge clk);
    a_in = 32'h55; b_in = 32'h77; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (5) @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    check(!busy && !done && product == '0, "R1 reset mid-run", product, '0);

    repeat (2) @(negedge clk);
    finish_run();
  end

endmodule